// File: doc/BRIEF.md
# Manchester Command/Response Word Receiver

This block takes the complementary receive pair of a serial bus transceiver and recovers 20-bit-time Manchester words from it: a three-bit-time sync field, sixteen data bits and an odd parity bit. The sync field tells command/status words from data words. Data bits are collected most significant first in a serial-to-parallel register on every word, but the parallel output register changes only when the whole word checks out. A valid word is marked by a one-clock low pulse on the strobe output.

Two timed windows accompany each word: a busy output that opens a fixed delay after the word starts, and a sync-type output that is high for the same window when the word carried command/status sync. When a valid command word carries this terminal's five-bit address in its leading bits, an address-hit pulse goes out alongside the strobe. An active-low power-on clear resets the receiver at any time and drops any word in progress.

The defaults assume a 12 MHz clock and 1 Mbit/s, which gives 12 clocks per bit cell. The receive lines are brought into the clock domain through two flip-flops. That adds up to three clocks of latency between a line change and the receiver's timing.

Top module: `manch_word_rx`

## Requirements
- R1: While and after power-on clear (porN low), rxBusy and syncCmd are 0, wordOut is 0, wordStrobeN is 1 and addrHit is 0.
- R2: rxBusy rises 60 to 64 clocks (5 bit-times plus input latency) after the first transition of a word and stays high for exactly 192 clocks (16 bit-times).
- R3: When a second word starts right after the first word's parity cell, rxBusy is low for exactly 48 clocks (4 bit-times) between the two busy windows.
- R4: The sync field is 1.5 bit-times at one level and 1.5 at the other. Positive line (rxPos=1, rxNeg=0) first means command/status, and syncCmd is then high for all 192 busy clocks. Negative first means data, and syncCmd then stays low.
- R5: Each data or parity cell is first half high then second half low for a 1, and the reverse for a 0. On a valid word, wordOut is loaded with the 16 data bits, the first bit received in bit 15, and wordStrobeN is low for exactly one clock.
- R6: A word whose parity bit makes the count of ones over data plus parity even gives no strobe and leaves wordOut unchanged.
- R7: A word with a data cell lacking its mid-cell transition gives no strobe and leaves wordOut unchanged.
- R8: A word whose line goes idle (both lines low) before its parity cell ends gives no strobe and leaves wordOut unchanged.
- R9: addrHit pulses high in the same clock as the strobe only when the word had command sync and wordOut[15:11] equals ownAddr. It stays low for data words and for other addresses.
- R10: Pulling porN low mid-word clears rxBusy at once, and that word never produces a strobe. The next word is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock, 12 per bit cell |
| porN | input | 1 | Active-low power-on clear / abort |
| rxPos | input | 1 | True receive line from transceiver |
| rxNeg | input | 1 | Complement receive line |
| ownAddr | input | 5 | This terminal's address |
| rxBusy | output | 1 | Word busy window |
| syncCmd | output | 1 | High during busy for command/status sync |
| wordOut | output | 16 | Last valid word received |
| wordStrobeN | output | 1 | One-clock low pulse on a valid word |
| addrHit | output | 1 | Pulse: valid command word for own address |

## Verification
The bench builds the block with its defaults of 12 clocks per bit, 16 data bits, a 5-bit address, a 5-bit-time busy delay and a 16-bit-time busy window. At 12 clocks per bit every quarter-cell sample point is a whole clock, so the exact window lengths of 192 and 48 clocks can be compared outright. The scoreboard predicts a strobe only for well-formed words. Parity, missing-transition and truncated words therefore show up as extra strobes, and back-to-back traffic and a mid-word clear run against the same prediction.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  // Strobes from the timing control to the datapath, one per sample point.
  typedef struct packed {
    logic       wordStart;
    logic [3:0] syncSmp;
    logic       halfA;
    logic       halfB;
    logic       lastCell;
    logic       busyStart;
  } ctlStrobes_t;

endpackage

// File: rtl/mwr_ctrl.sv
module mwr_ctrl
  import mwr_pkg::*;
#(
  parameter int CLKS_PER_BIT    = 12,
  parameter int DATA_BITS       = 16,
  parameter int BUSY_DELAY_BITS = 5,
  parameter int BUSY_BITS       = 16
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        rxPos,
  input  logic        rxNeg,
  output logic        lineLvl,
  output logic        lineAct,
  output ctlStrobes_t strb,
  output logic        rxBusy
);

  localparam int SyncBits = 3;
  localparam int WordBits = SyncBits + DATA_BITS + 1;
  localparam int PhW      = $clog2(CLKS_PER_BIT);
  localparam int CellW    = $clog2(WordBits);
  localparam int BusyW    = $clog2(BUSY_BITS * CLKS_PER_BIT + 1);

  localparam logic [PhW-1:0]   PhQ1   = PhW'(CLKS_PER_BIT / 4);
  localparam logic [PhW-1:0]   PhQ3   = PhW'((3 * CLKS_PER_BIT) / 4);
  localparam logic [PhW-1:0]   PhMid  = PhW'(CLKS_PER_BIT / 2);
  localparam logic [PhW-1:0]   PhLast = PhW'(CLKS_PER_BIT - 1);
  localparam logic [PhW-1:0]   PhZero = PhW'(0);
  localparam logic [CellW-1:0] Cell0  = CellW'(0);
  localparam logic [CellW-1:0] Cell1  = CellW'(1);
  localparam logic [CellW-1:0] Cell2  = CellW'(2);
  localparam logic [CellW-1:0] FirstDataCell = CellW'(SyncBits);
  localparam logic [CellW-1:0] LastCell      = CellW'(WordBits - 1);
  localparam logic [CellW-1:0] BusyCell      = CellW'(BUSY_DELAY_BITS);
  localparam logic [BusyW-1:0] BusyLoad      = BusyW'(BUSY_BITS * CLKS_PER_BIT);

  logic [1:0]       posSync, negSync;
  logic             running;
  logic [PhW-1:0]   phaseCnt;
  logic [CellW-1:0] cellCnt;
  logic [BusyW-1:0] busyCnt;
  logic             atWordEdge;

  // Two-stage capture of the receive pair.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      posSync <= '0;
      negSync <= '0;
    end else begin
      posSync <= {posSync[0], rxPos};
      negSync <= {negSync[0], rxNeg};
    end
  end

  assign lineLvl    = posSync[1];
  assign lineAct    = posSync[1] ^ negSync[1];
  assign atWordEdge = running && (cellCnt == Cell0) && (phaseCnt == PhZero);

  always_comb begin
    strb           = '0;
    strb.wordStart = lineAct && (!running || atWordEdge);
    strb.lastCell  = (cellCnt == LastCell);
    if (running) begin
      strb.syncSmp[0] = (cellCnt == Cell0) && (phaseCnt == PhMid);
      strb.syncSmp[1] = (cellCnt == Cell1) && (phaseCnt == PhQ1);
      strb.syncSmp[2] = (cellCnt == Cell1) && (phaseCnt == PhQ3);
      strb.syncSmp[3] = (cellCnt == Cell2) && (phaseCnt == PhMid);
      strb.halfA      = (cellCnt >= FirstDataCell) && (phaseCnt == PhQ1);
      strb.halfB      = (cellCnt >= FirstDataCell) && (phaseCnt == PhQ3);
      strb.busyStart  = (cellCnt == BusyCell) && (phaseCnt == PhZero);
    end
  end

  // Bit-cell timing: phase within a cell, cell within a word.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      running  <= 1'b0;
      phaseCnt <= '0;
      cellCnt  <= '0;
    end else if (!running) begin
      if (lineAct) begin
        running  <= 1'b1;
        phaseCnt <= PhW'(1);
        cellCnt  <= '0;
      end
    end else if (atWordEdge && !lineAct) begin
      running <= 1'b0;
    end else if (phaseCnt == PhLast) begin
      phaseCnt <= '0;
      cellCnt  <= (cellCnt == LastCell) ? '0 : cellCnt + 1'b1;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // Busy window runs on its own so it can outlast the word that opened it.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      busyCnt <= '0;
    end else if (strb.busyStart) begin
      busyCnt <= BusyLoad;
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  assign rxBusy = (busyCnt != '0);

  assert_busy_closed_R3: assert property (@(posedge clk) disable iff (!porN)
    strb.busyStart |-> !rxBusy)
    else $error("busy window reopened before it closed");

  assert_busy_in_word_R2: assert property (@(posedge clk) disable iff (!porN)
    $rose(rxBusy) |-> running)
    else $error("busy rose outside a word");

endmodule

// File: rtl/mwr_datapath.sv
module mwr_datapath
  import mwr_pkg::*;
#(
  parameter int DATA_BITS = 16,
  parameter int ADDR_BITS = 5
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 lineLvl,
  input  logic                 lineAct,
  input  ctlStrobes_t          strb,
  input  logic                 busyIn,
  input  logic [ADDR_BITS-1:0] ownAddr,
  output logic                 syncCmd,
  output logic [DATA_BITS-1:0] wordOut,
  output logic                 wordStrobeN,
  output logic                 addrHit
);

  logic                 firstLvl, syncGood, halfLvl, halfAct;
  logic                 cellsOk, parAcc, syncLat;
  logic [DATA_BITS-1:0] shiftReg;
  logic                 cellOk, wordGood;

  assign cellOk   = halfAct && lineAct && (lineLvl != halfLvl);
  assign wordGood = cellsOk && cellOk && syncGood && (parAcc ^ halfLvl);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      firstLvl    <= 1'b0;
      syncGood    <= 1'b0;
      halfLvl     <= 1'b0;
      halfAct     <= 1'b0;
      cellsOk     <= 1'b0;
      parAcc      <= 1'b0;
      syncLat     <= 1'b0;
      shiftReg    <= '0;
      wordOut     <= '0;
      wordStrobeN <= 1'b1;
      addrHit     <= 1'b0;
    end else begin
      wordStrobeN <= 1'b1;
      addrHit     <= 1'b0;
      if (strb.wordStart) begin
        syncGood <= 1'b1;
        cellsOk  <= 1'b1;
        parAcc   <= 1'b0;
      end
      if (strb.syncSmp[0]) begin
        firstLvl <= lineLvl;
        syncGood <= syncGood & lineAct;
      end
      if (strb.syncSmp[1])
        syncGood <= syncGood & lineAct & (lineLvl == firstLvl);
      if (strb.syncSmp[2] || strb.syncSmp[3])
        syncGood <= syncGood & lineAct & (lineLvl != firstLvl);
      if (strb.halfA) begin
        halfLvl <= lineLvl;
        halfAct <= lineAct;
      end
      if (strb.halfB) begin
        if (!strb.lastCell) begin
          shiftReg <= {shiftReg[DATA_BITS-2:0], halfLvl};
          parAcc   <= parAcc ^ halfLvl;
          cellsOk  <= cellsOk & cellOk;
        end else if (wordGood) begin
          wordOut     <= shiftReg;
          wordStrobeN <= 1'b0;
          addrHit     <= firstLvl &&
                         (shiftReg[DATA_BITS-1 -: ADDR_BITS] == ownAddr);
        end
      end
      if (strb.busyStart)
        syncLat <= firstLvl && syncGood;
    end
  end

  assign syncCmd = busyIn && syncLat;

  assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (!porN)
    !wordStrobeN |=> wordStrobeN)
    else $error("strobe wider than one clock");

  assert_hit_with_strobe_R9: assert property (@(posedge clk) disable iff (!porN)
    addrHit |-> !wordStrobeN)
    else $error("address hit without valid word");

  assert_sync_steady_R4: assert property (@(posedge clk) disable iff (!porN)
    (busyIn && $past(busyIn)) |-> $stable(syncCmd))
    else $error("sync type changed inside busy window");

endmodule

// File: rtl/manch_word_rx.sv
module manch_word_rx
  import mwr_pkg::*;
#(
  parameter int CLKS_PER_BIT    = 12,
  parameter int DATA_BITS       = 16,
  parameter int ADDR_BITS       = 5,
  parameter int BUSY_DELAY_BITS = 5,
  parameter int BUSY_BITS       = 16
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 rxPos,
  input  logic                 rxNeg,
  input  logic [ADDR_BITS-1:0] ownAddr,
  output logic                 rxBusy,
  output logic                 syncCmd,
  output logic [DATA_BITS-1:0] wordOut,
  output logic                 wordStrobeN,
  output logic                 addrHit
);

  logic        lineLvl, lineAct;
  ctlStrobes_t strb;

  mwr_ctrl #(
    .CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(DATA_BITS),
    .BUSY_DELAY_BITS(BUSY_DELAY_BITS), .BUSY_BITS(BUSY_BITS)
  ) uCtrl (
    .clk(clk), .porN(porN), .rxPos(rxPos), .rxNeg(rxNeg),
    .lineLvl(lineLvl), .lineAct(lineAct), .strb(strb), .rxBusy(rxBusy)
  );

  mwr_datapath #(.DATA_BITS(DATA_BITS), .ADDR_BITS(ADDR_BITS)) uData (
    .clk(clk), .porN(porN), .lineLvl(lineLvl), .lineAct(lineAct),
    .strb(strb), .busyIn(rxBusy), .ownAddr(ownAddr), .syncCmd(syncCmd),
    .wordOut(wordOut), .wordStrobeN(wordStrobeN), .addrHit(addrHit)
  );

  assert_strobe_in_busy_R5: assert property (@(posedge clk) disable iff (!porN)
    !wordStrobeN |-> rxBusy)
    else $error("valid-word strobe outside busy window");

endmodule

// File: tb/sim_manch_word_rx.sv
module sim_manch_word_rx;

  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        rxPos = 1'b0;
  logic        rxNeg = 1'b0;
  logic [4:0]  ownAddr = 5'h13;
  logic        rxBusy, syncCmd, wordStrobeN, addrHit;
  logic [15:0] wordOut;

  manch_word_rx u0 (
    .clk(clk), .porN(porN), .rxPos(rxPos), .rxNeg(rxNeg), .ownAddr(ownAddr),
    .rxBusy(rxBusy), .syncCmd(syncCmd), .wordOut(wordOut),
    .wordStrobeN(wordStrobeN), .addrHit(addrHit)
  );

  always #4 clk = ~clk;

  typedef struct { logic [15:0] d; logic hit; } exp_t;
  exp_t expQ[$];
  exp_t e;

  int cyc = 0, checks = 0, fails = 0, strobes = 0;
  int hiLen = 0, syncHi = 0, loLen = 0, lastHi = 0, lastSync = 0, lastLo = 0;
  int riseCyc = 0, startCyc = 0;
  logic prevBusy = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: busy/sync windows and scoreboard for valid-word strobes.
  always @(negedge clk) begin
    if (rxBusy) begin
      if (!prevBusy) begin lastLo = loLen; riseCyc = cyc; hiLen = 0; syncHi = 0; end
      hiLen++;
      if (syncCmd) syncHi++;
    end else begin
      if (prevBusy) begin lastHi = hiLen; lastSync = syncHi; loLen = 0; end
      loLen++;
    end
    prevBusy = rxBusy;
    if (!wordStrobeN) begin
      strobes++;
      if (expQ.size() == 0) chk(1'b0, "R6/R7/R8 unexpected strobe", int'(wordOut), -1);
      else begin
        e = expQ.pop_front();
        chk(wordOut == e.d, "R5 wordOut", int'(wordOut), int'(e.d));
        chk(addrHit == e.hit, "R9 addrHit", int'(addrHit), int'(e.hit));
      end
    end else if (addrHit) chk(1'b0, "R9 hit without strobe", 1, 0);
  end

  task automatic lvl(input logic v, input int n);
    rxPos = v; rxNeg = ~v;
    repeat (n) @(negedge clk);
  endtask

  task automatic idle(input int n);
    rxPos = 1'b0; rxNeg = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Driver: pushes the expected result, then drives the word cell by cell.
  task automatic sendWord(input logic cmd, input logic [15:0] d, input bit flipPar,
                          input int badCell, input int nCells);
    exp_t x;
    startCyc = cyc;
    if (!flipPar && badCell < 0 && nCells == 17) begin
      x.d = d; x.hit = cmd && (d[15:11] == ownAddr);
      expQ.push_back(x);
    end
    lvl(cmd, 18); lvl(~cmd, 18);
    for (int k = 0; k < nCells; k++) begin
      logic b;
      b = (k < 16) ? d[15-k] : ((~^d) ^ flipPar);
      lvl(b, 6);
      lvl((k == badCell) ? b : ~b, 6);
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    chk(rxBusy == 0, "R1 busy", rxBusy, 0);
    chk(syncCmd == 0, "R1 syncCmd", syncCmd, 0);
    chk(wordOut == 0, "R1 wordOut", int'(wordOut), 0);
    chk(wordStrobeN == 1, "R1 strobe", wordStrobeN, 1);
    chk(addrHit == 0, "R1 addrHit", addrHit, 0);
    porN = 1'b1;
    idle(5);

    // Command word for own address.
    sendWord(1'b1, 16'h9ABC, 0, -1, 17); idle(30);
    chk(strobes == 1, "R5 strobe count", strobes, 1);
    chk(lastHi == 192, "R2 busy length", lastHi, 192);
    chk(riseCyc - startCyc >= 60 && riseCyc - startCyc <= 64, "R2 busy delay",
        riseCyc - startCyc, 60);
    chk(lastSync == 192, "R4 syncCmd cmd", lastSync, 192);

    // Data word with the same leading bits: no hit, syncCmd low.
    sendWord(1'b0, 16'h9ABC, 0, -1, 17); idle(30);
    chk(lastSync == 0, "R4 syncCmd data", lastSync, 0);
    chk(strobes == 2, "R9 data strobe count", strobes, 2);

    // Command word, other address.
    sendWord(1'b1, 16'h1234, 0, -1, 17); idle(30);
    chk(strobes == 3, "R9 mismatch strobe count", strobes, 3);

    // Parity error.
    s = strobes;
    sendWord(1'b1, 16'h9F00, 1, -1, 17); idle(30);
    chk(strobes == s, "R6 no strobe", strobes, s);
    chk(wordOut == 16'h1234, "R6 wordOut held", int'(wordOut), 'h1234);

    // Missing mid-cell transition.
    sendWord(1'b1, 16'h9F00, 0, 7, 17); idle(30);
    chk(strobes == s, "R7 no strobe", strobes, s);
    chk(wordOut == 16'h1234, "R7 wordOut held", int'(wordOut), 'h1234);

    // Truncated word.
    sendWord(1'b0, 16'h5555, 0, -1, 10); idle(300);
    chk(strobes == s, "R8 no strobe", strobes, s);
    chk(wordOut == 16'h1234, "R8 wordOut held", int'(wordOut), 'h1234);

    // Back-to-back words.
    sendWord(1'b0, 16'h0F0F, 0, -1, 17);
    sendWord(1'b1, 16'h98F1, 0, -1, 17); idle(30);
    chk(lastLo == 48, "R3 busy gap", lastLo, 48);
    chk(strobes == s + 2, "R3 both words", strobes, s + 2);
    chk(lastHi == 192, "R2 second busy length", lastHi, 192);

    // Abort mid-word by power-on clear.
    s = strobes;
    lvl(1'b1, 18); lvl(1'b0, 18);
    for (int k = 0; k < 6; k++) begin lvl(1'b1, 6); lvl(1'b0, 6); end
    chk(rxBusy == 1, "R2 busy mid-word", rxBusy, 1);
    rxPos = 1'b0; rxNeg = 1'b0; porN = 1'b0;
    repeat (2) @(negedge clk);
    chk(rxBusy == 0, "R10 busy cleared", rxBusy, 0);
    chk(syncCmd == 0, "R10 syncCmd cleared", syncCmd, 0);
    porN = 1'b1;
    idle(300);
    chk(strobes == s, "R10 no strobe after abort", strobes, s);
    sendWord(1'b0, 16'h0001, 0, -1, 17); idle(30);
    chk(strobes == s + 1, "R10 recovery strobe", strobes, s + 1);

    chk(expQ.size() == 0, "R5 all expected words seen", expQ.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule